// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two fixed-point numbers that are each held as a separate sign bit and an unsigned magnitude. A start pulse loads both operands and the operation select. The block first works out whether the magnitudes must really be added or subtracted. It then runs the magnitude adder once, and in a second cycle it corrects the result if needed. The result is written back into the accumulator operand (sign and magnitude). A carry flag and an overflow flag are also kept.

If the magnitudes were subtracted and the carry flag ends up clear, the subtrahend was the larger value. In that case the accumulator magnitude is replaced by its two's complement and its sign is flipped. A zero result from a magnitude subtraction always carries a positive sign. Every operation takes the same two cycles after start. A one-cycle done pulse marks the point where the results are valid.

Top module: `smag_addsub`

## Requirements
- R1: After a synchronous active-low reset, done and busy are 0, and the result sign, result magnitude, carry flag and overflow flag are all 0.
- R2: When start is sampled high while idle, done is high for exactly one cycle: the cycle after the second rising edge that follows the loading edge. busy is high between the loading edge and that pulse.
- R3: The operation is an effective add when the accumulator sign equals the operand sign (after the adjustment of R4). For an effective add, the result magnitude is (A + B) mod 2^W, the carry flag is the carry out of that sum, the overflow flag equals the carry flag, and the result sign is the accumulator sign.
- R4: When op_sub is 1, the operand sign b_sign_in is inverted before it is compared with the accumulator sign. When op_sub is 0, the operand sign is used as given.
- R5: For an effective subtract with A >= B, the result magnitude is A - B, the sign is the accumulator sign, the carry flag is 1 and the overflow flag is 0.
- R6: For an effective subtract with A < B, the result magnitude is B - A, the sign is the inverse of the accumulator sign, the carry flag is 0 and the overflow flag is 0.
- R7: An effective subtract that gives a zero magnitude always gives result sign 0.
- R8: A start pulse while busy is high is ignored. The running operation completes with its own operands, and no extra done pulse follows.
- R9: While idle with start low, the result sign, magnitude and both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load operands and begin an operation (while idle) |
| op_sub | input | 1 | 1 = subtract the operand, 0 = add it |
| a_sign_in | input | 1 | Accumulator operand sign (1 = negative) |
| a_mag_in | input | W | Accumulator operand magnitude |
| b_sign_in | input | 1 | Second operand sign (1 = negative) |
| b_mag_in | input | W | Second operand magnitude |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| res_sign | output | 1 | Accumulator sign (result) |
| res_mag | output | W | Accumulator magnitude (result) |
| carry_e | output | 1 | Carry flag from the magnitude adder |
| ovf | output | 1 | Overflow flag |

## Verification
The bench covers equal magnitudes under every sign and op combination. A design that skips the sign fix would return a negative zero there, and one with an off-by-one carry would flag a borrow. It also drives subtractions where B exceeds A by one, and maximum magnitudes on both sides. These expose a missing two's-complement correction, a sign left unflipped, and an overflow flag that is set on subtracts or lost when an add wraps. Start pulses arriving mid-operation check for a reload of operands or a second done pulse. Idle stretches after each result catch registers that drift while nothing runs.

// File: rtl/smag_pkg.sv
// Shared types for the signed-magnitude adder/subtractor.
package smag_pkg;
    // Sequencer phases: idle, magnitude add, correction.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADD  = 2'd1,
        PH_FIX  = 2'd2
    } smag_phase_e;
endpackage

// File: rtl/smag_op_decode.sv
// Decides whether the magnitudes are added or subtracted.
// The operand sign is inverted for a subtract. The operation is then an
// effective subtract when the two signs differ. Purely combinational.
module smag_op_decode (
    input  logic op_sub,
    input  logic a_sign,
    input  logic b_sign,
    output logic eff_sub
);
    logic b_sign_adj;

    // Adjust the operand sign, then compare it with the accumulator sign.
    always_comb begin
        b_sign_adj = b_sign ^ op_sub;
        eff_sub    = a_sign ^ b_sign_adj;
    end
endmodule

// File: rtl/smag_mag_adder.sv
// Unsigned ripple-carry magnitude adder with an optional invert on y.
// Computes x + (inv_y ? ~y : y) + cin. Assumes W >= 1.
module smag_mag_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         inv_y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   carry;
    logic [W-1:0] y_eff;

    // Conditional one's complement of the second input.
    always_comb y_eff = inv_y ? ~y : y;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One full-adder stage.
        always_comb begin
            sum[i]     = x[i] ^ y_eff[i] ^ carry[i];
            carry[i+1] = (x[i] & y_eff[i]) | (carry[i] & (x[i] ^ y_eff[i]));
        end
    end

    assign cout = carry[W];
endmodule

// File: rtl/smag_seq.sv
// Fixed two-phase sequencer. A start seen while idle loads the operands.
// The sequencer then steps through the add phase and the fix phase, and
// pulses done for one cycle. Start is ignored while busy.
module smag_seq
    import smag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic ph_add,
    output logic ph_fix,
    output logic busy,
    output logic done
);
    smag_phase_e state_q, state_d;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PH_IDLE: if (start) state_d = PH_ADD;
            PH_ADD:  state_d = PH_FIX;
            PH_FIX:  state_d = PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == PH_FIX);
        end
    end

    // Phase decodes for the datapath.
    always_comb begin
        load   = (state_q == PH_IDLE) && start;
        ph_add = (state_q == PH_ADD);
        ph_fix = (state_q == PH_FIX);
        busy   = (state_q != PH_IDLE);
    end

    // R2: done follows the fix phase and lasts one cycle.
    p_done_after_fix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_fix |=> done);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a start during the add phase does not restart the sequence.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ph_add |=> ph_fix);
endmodule

// File: rtl/smag_addsub.sv
// Signed-magnitude adder/subtractor, top level.
// The accumulator operand (sign and magnitude) is loaded on start and is
// overwritten with the result. The add phase runs the magnitude adder once
// and captures the carry. The fix phase takes the two's complement of the
// magnitude and flips the sign when an effective subtract gives carry 0.
// Assumes W >= 1.
module smag_addsub #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sub,
    input  logic         a_sign_in,
    input  logic [W-1:0] a_mag_in,
    input  logic         b_sign_in,
    input  logic [W-1:0] b_mag_in,
    output logic         busy,
    output logic         done,
    output logic         res_sign,
    output logic [W-1:0] res_mag,
    output logic         carry_e,
    output logic         ovf
);
    localparam logic [W-1:0] MAG_ZERO = '0;

    logic         load, ph_add, ph_fix;
    logic         eff_sub_in, eff_sub_q;
    logic         acc_sign_q, e_q, avf_q;
    logic [W-1:0] acc_mag_q, opb_mag_q;
    logic [W-1:0] add_x, add_y, add_sum;
    logic         add_inv, add_cin, add_cout;

    smag_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .ph_add (ph_add),
        .ph_fix (ph_fix),
        .busy   (busy),
        .done   (done)
    );

    smag_op_decode u_dec (
        .op_sub  (op_sub),
        .a_sign  (a_sign_in),
        .b_sign  (b_sign_in),
        .eff_sub (eff_sub_in)
    );

    // Adder operands: A +/- B in the add phase, 0 + ~A + 1 in the fix phase.
    always_comb begin
        add_x   = ph_fix ? MAG_ZERO : acc_mag_q;
        add_y   = ph_fix ? acc_mag_q : opb_mag_q;
        add_inv = ph_fix | eff_sub_q;
        add_cin = ph_fix | eff_sub_q;
    end

    smag_mag_adder #(.W(W)) u_add (
        .x     (add_x),
        .y     (add_y),
        .inv_y (add_inv),
        .cin   (add_cin),
        .sum   (add_sum),
        .cout  (add_cout)
    );

    // Operand load, add phase and fix phase updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_mag_q  <= '0;
            acc_sign_q <= 1'b0;
            opb_mag_q  <= '0;
            eff_sub_q  <= 1'b0;
            e_q        <= 1'b0;
            avf_q      <= 1'b0;
        end else if (load) begin
            acc_mag_q  <= a_mag_in;
            acc_sign_q <= a_sign_in;
            opb_mag_q  <= b_mag_in;
            eff_sub_q  <= eff_sub_in;
        end else if (ph_add) begin
            acc_mag_q <= add_sum;
            e_q       <= add_cout;
            avf_q     <= eff_sub_q ? 1'b0 : add_cout;
            if (eff_sub_q && (add_sum == MAG_ZERO))
                acc_sign_q <= 1'b0;
        end else if (ph_fix) begin
            if (eff_sub_q && !e_q) begin
                acc_mag_q  <= add_sum;
                acc_sign_q <= ~acc_sign_q;
            end
        end
    end

    // Result ports.
    always_comb begin
        res_sign = acc_sign_q;
        res_mag  = acc_mag_q;
        carry_e  = e_q;
        ovf      = avf_q;
    end

    // R3: an effective add reports overflow equal to the carry.
    p_ovf_is_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !eff_sub_q) |-> (ovf == carry_e));
    // R5: an effective subtract never reports overflow.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && eff_sub_q) |-> !ovf);
    // R6: a borrowing subtract leaves a non-zero magnitude.
    p_borrow_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && eff_sub_q && !carry_e) |-> (res_mag != MAG_ZERO));
    // R7: no negative zero from a subtract.
    p_no_neg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && eff_sub_q && (res_mag == MAG_ZERO)) |-> !res_sign);
    // R9: results hold while idle with no start.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_mag) && $stable(res_sign)
                               && $stable(carry_e) && $stable(ovf)));
endmodule

// File: tb/smag_addsub_test.sv
// Self-checking bench: directed corners plus seeded random operations,
// compared against a behavioural signed-magnitude model.
module smag_addsub_test;
    localparam int W = 8;

    typedef struct packed {
        logic         sign;
        logic [W-1:0] mag;
        logic         e;
        logic         avf;
    } res_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic         a_sign_in = 1'b0;
    logic [W-1:0] a_mag_in = '0;
    logic         b_sign_in = 1'b0;
    logic [W-1:0] b_mag_in = '0;
    logic         busy, done, res_sign, carry_e, ovf;
    logic [W-1:0] res_mag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    smag_addsub #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .a_sign_in(a_sign_in), .a_mag_in(a_mag_in),
        .b_sign_in(b_sign_in), .b_mag_in(b_mag_in),
        .busy(busy), .done(done), .res_sign(res_sign), .res_mag(res_mag),
        .carry_e(carry_e), .ovf(ovf)
    );

    // Reference model (R3..R7).
    function automatic res_t model(input logic sub, input logic as,
                                   input logic [W-1:0] a, input logic bs,
                                   input logic [W-1:0] b);
        res_t r;
        logic [W:0] s;
        logic effsub;
        effsub = as ^ bs ^ sub;
        if (!effsub) begin
            s = {1'b0, a} + {1'b0, b};
            r.mag = s[W-1:0]; r.e = s[W]; r.avf = s[W]; r.sign = as;
        end else if (a >= b) begin
            r.mag = a - b; r.e = 1'b1; r.avf = 1'b0;
            r.sign = (a == b) ? 1'b0 : as;
        end else begin
            r.mag = b - a; r.e = 1'b0; r.avf = 1'b0; r.sign = ~as;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_res(input res_t exp, input string req);
        res_t act;
        act = {res_sign, res_mag, carry_e, ovf};
        check(act == exp, req, "result {sign,mag,e,avf}", act, exp);
    endtask

    // One operation; optional stray start while busy (R8).
    task automatic run_op(input logic sub, input logic as, input logic [W-1:0] a,
                          input logic bs, input logic [W-1:0] b,
                          input bit stray, input string req);
        res_t exp;
        exp = model(sub, as, a, bs, b);
        @(negedge clk);
        op_sub = sub; a_sign_in = as; a_mag_in = a; b_sign_in = bs; b_mag_in = b;
        start = 1'b1;
        @(posedge clk);            // loading edge
        @(negedge clk);
        start = stray;
        if (stray) begin
            a_mag_in = ~a; b_mag_in = ~b; a_sign_in = ~as; op_sub = ~sub;
        end
        check(busy == 1'b1, "R2", "busy after load", busy, 1);
        check(done == 1'b0, "R2", "done early", done, 0);
        @(posedge clk);            // add phase
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R2", "done after add phase", done, 0);
        @(posedge clk);            // fix phase
        @(negedge clk);
        check(done == 1'b1, "R2", "done pulse", done, 1);
        check_res(exp, req);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, stray ? "R8" : "R2", "done second cycle", done, 0);
        check(busy == 1'b0, stray ? "R8" : "R2", "busy after done", busy, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R8", "no extra done", done, 0);
        check_res(exp, "R9");      // idle hold
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check({busy, done, res_sign, res_mag, carry_e, ovf} == '0, "R1",
              "reset state", {busy, done, res_sign, res_mag, carry_e, ovf}, 0);

        // Directed corners.
        run_op(1'b0, 1'b0, 8'd20, 1'b0, 8'd30, 0, "R3");   // +20 + +30
        run_op(1'b0, 1'b1, 8'd200, 1'b1, 8'd100, 0, "R3"); // wrap, overflow
        run_op(1'b0, 1'b0, 8'hFF, 1'b0, 8'hFF, 0, "R3");   // max + max
        run_op(1'b1, 1'b0, 8'd50, 1'b1, 8'd25, 0, "R4");   // 50 - (-25) = add
        run_op(1'b1, 1'b0, 8'd50, 1'b0, 8'd25, 0, "R5");   // 50 - 25
        run_op(1'b0, 1'b1, 8'd90, 1'b0, 8'd10, 0, "R5");   // -90 + 10
        run_op(1'b1, 1'b0, 8'd10, 1'b0, 8'd11, 0, "R6");   // B = A + 1
        run_op(1'b0, 1'b1, 8'd0, 1'b0, 8'hFF, 0, "R6");    // -0 + 255
        run_op(1'b1, 1'b1, 8'd77, 1'b1, 8'd77, 0, "R7");   // -77 - (-77)
        run_op(1'b0, 1'b1, 8'd5, 1'b0, 8'd5, 0, "R7");     // -5 + 5
        run_op(1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 0, "R7");     // 0 - 0
        run_op(1'b1, 1'b1, 8'd3, 1'b0, 8'd9, 1, "R8");     // stray start
        run_op(1'b0, 1'b0, 8'd200, 1'b1, 8'd201, 1, "R8");

        // Seeded random mix.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            run_op(r[0], r[1], r[15:8], r[2], r[23:16], r[3] & r[4], "R3-R7 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule